// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Sequencer

This block is an SPI master that reads an external serial converter with up to eight inputs. A trigger either starts a scan over the channels picked by an enable mask or starts a direct read of one channel. For each selected channel the block sends one 16-bit command frame. It keeps chip select low for the whole burst and returns the results, each tagged with its channel, on a valid/ready stream.

The converter answers each command one frame late. The reply clocked in during the first frame of a burst is therefore thrown away. After the last command the block sends one all-zero frame to fetch the final result, and it labels each reply with the channel that the previous frame addressed. SCLK comes from the system clock through an even divider of `2*HALF_DIV` cycles per SCLK period.

Back-pressure rule: while `res_valid` is high and `res_ready` is low, the result, its channel tag and its last flag hold steady. No further frame starts until the consumer accepts the result. `res_ready` may change in any cycle and does not depend on `res_valid`.

Top module: `spi_adc_scan`

## Requirements
- R1: SPI mode 3. SCLK rests high whenever chip select is released and between frames. MOSI changes on SCLK falling edges and MISO is sampled on rising edges.
- R2: Every frame has exactly 16 SCLK rising edges, most significant bit first. A command frame puts the channel number in bits 13..11, and all of its other bits are zero.
- R3: In scan mode the command frames address the channels whose mask bit is 1, lowest index first. There is one frame per set bit and no frame for a clear bit.
- R4: A burst ends with one extra frame of all zeros, so a burst has one frame more than its channel count. The reply received during the first frame produces no result.
- R5: Each result is bits 11..0 of the reply received in frame k+1, tagged with the channel commanded in frame k. Bits 15..12 of the reply are dropped.
- R6: `res_last` is 1 on the final result of a burst and 0 on every other result.
- R7: When `direct_rd` is 1 at the trigger, the burst is two frames: a command for `direct_ch`, then the dummy frame. The mask is ignored and one result is produced, flagged last.
- R8: `cs_n` stays low from before the first frame until after the last frame. It falls at least `HALF_DIV` clock cycles before the first SCLK fall and rises at least `HALF_DIV` cycles after the last SCLK rise.
- R9: A trigger that arrives while `busy` is 1 does not change the burst in progress. It raises `overrun` for one cycle, in the cycle after that trigger.
- R10: A trigger with `direct_rd` 0 and an all-zero mask starts nothing: `busy` stays 0 and `cs_n` stays high.
- R11: While `res_valid` is 1 and `res_ready` is 0, the result fields hold steady and SCLK does not toggle.
- R12: After reset `cs_n` is 1, `sclk` is 1, and `res_valid`, `busy` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Start request, sampled on each rising clock edge |
| chan_mask | input | 8 | Channel enable mask for scan mode, bit i selects channel i |
| direct_rd | input | 1 | 1 selects a single-channel direct read at the trigger |
| direct_ch | input | 3 | Channel for a direct read |
| busy | output | 1 | A burst is in progress |
| overrun | output | 1 | One-cycle pulse: a trigger arrived while busy |
| sclk | output | 1 | SPI clock, idles high |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |
| res_valid | output | 1 | A result is presented |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Conversion result |
| res_chan | output | 3 | Channel the result belongs to |
| res_last | output | 1 | Final result of the burst |

## Verification
The assertions assume that every input is synchronous to `clk`, that `res_ready` may change freely, and that `chan_mask`, `direct_rd` and `direct_ch` only matter in the cycle in which `trig` is seen. The bench changes every input on the falling clock edge. It holds each trigger for exactly one cycle and changes the mask only alongside a trigger. It draws `res_ready` at random or holds it high, and it drives MISO from a converter model that updates only on SCLK falls seen through `cs_n`. The overrun test deliberately retriggers in the middle of a burst with a different mask.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W  = 16;  // bits per SPI frame
  localparam int CH_W     = 3;   // channel field width
  localparam int CMD_LSB  = 11;  // lowest bit of the channel field in a command
  localparam int RES_W    = 12;  // result width kept from a reply

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_LAUNCH,
    SQ_FRAME,
    SQ_OUTW,
    SQ_HOLD
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] cmd_word(input logic [CH_W-1:0] ch);
    cmd_word = FRAME_W'(ch) << CMD_LSB;
  endfunction
endpackage

// File: rtl/spi_frame_engine.sv
// Shifts one mode-3 frame: data out on SCLK falls, data in on SCLK rises.
module spi_frame_engine #(
  parameter int HALF_DIV = 2,
  parameter int FW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] tx_word,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          done,
  output logic [FW-1:0] rx_word
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(FW);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [BW-1:0] bit_cnt;
  logic [FW-1:0] txsr, rxsr;
  logic          sclk_q, mosi_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      txsr    <= '0;
      rxsr    <= '0;
      sclk_q  <= 1'b1;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        div_cnt <= '0;
        bit_cnt <= '0;
        txsr    <= tx_word;
      end else if (active) begin
        if (div_cnt == DW'(HALF_DIV - 1)) begin
          div_cnt <= '0;
          if (sclk_q) begin
            sclk_q <= 1'b0;
            mosi_q <= txsr[FW-1];
            txsr   <= {txsr[FW-2:0], 1'b0};
          end else begin
            sclk_q  <= 1'b1;
            rxsr    <= {rxsr[FW-2:0], miso};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BW'(FW - 1)) begin
              active <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_word = rxsr;
endmodule

// File: rtl/scan_sequencer.sv
// Burst control: chip select window, channel order, reply re-tagging, output register.
module scan_sequencer
  import adc_scan_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int NCH      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic [NCH-1:0]     chan_mask,
  input  logic               direct_rd,
  input  logic [CH_W-1:0]    direct_ch,
  input  logic               eng_done,
  input  logic [FRAME_W-1:0] eng_rx,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_tx,
  output logic               cs_n,
  output logic               busy,
  output logic               overrun,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [RES_W-1:0]   res_data,
  output logic [CH_W-1:0]    res_chan,
  output logic               res_last
);
  localparam int WW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  seq_state_t      state;
  logic [NCH-1:0]  pend;
  logic [WW-1:0]   wait_cnt;
  logic [CH_W-1:0] low_idx, cur_ch, prev_ch;
  logic            cur_dummy, have_prev, cs_q, ovr_q;

  always_comb begin
    low_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = CH_W'(i);
    end
  end

  assign eng_start = (state == SQ_LAUNCH);
  assign eng_tx    = (pend != '0) ? cmd_word(low_idx) : '0;
  assign busy      = (state != SQ_IDLE);
  assign cs_n      = cs_q;
  assign overrun   = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      pend      <= '0;
      wait_cnt  <= '0;
      cur_ch    <= '0;
      prev_ch   <= '0;
      cur_dummy <= 1'b0;
      have_prev <= 1'b0;
      cs_q      <= 1'b1;
      ovr_q     <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      res_last  <= 1'b0;
    end else begin
      ovr_q <= trig && (state != SQ_IDLE);
      unique case (state)
        SQ_IDLE: begin
          if (trig && (direct_rd || chan_mask != '0)) begin
            pend      <= direct_rd ? (NCH'(1) << direct_ch) : chan_mask;
            have_prev <= 1'b0;
            wait_cnt  <= '0;
            cs_q      <= 1'b0;
            state     <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          if (wait_cnt == WW'(HALF_DIV - 1)) begin
            wait_cnt <= '0;
            state    <= SQ_LAUNCH;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        SQ_LAUNCH: begin
          cur_ch    <= low_idx;
          cur_dummy <= (pend == '0);
          if (pend != '0) pend[low_idx] <= 1'b0;
          state <= SQ_FRAME;
        end
        SQ_FRAME: begin
          if (eng_done) begin
            have_prev <= 1'b1;
            prev_ch   <= cur_ch;
            if (have_prev) begin
              res_valid <= 1'b1;
              res_data  <= eng_rx[RES_W-1:0];
              res_chan  <= prev_ch;
              res_last  <= cur_dummy;
              state     <= SQ_OUTW;
            end else begin
              state <= SQ_LAUNCH;
            end
          end
        end
        SQ_OUTW: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            wait_cnt  <= '0;
            state     <= cur_dummy ? SQ_HOLD : SQ_LAUNCH;
          end
        end
        SQ_HOLD: begin
          if (wait_cnt == WW'(HALF_DIV - 1)) begin
            cs_q  <= 1'b1;
            state <= SQ_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_adc_scan.sv
module spi_adc_scan
  import adc_scan_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int NCH      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [NCH-1:0]   chan_mask,
  input  logic             direct_rd,
  input  logic [CH_W-1:0]  direct_ch,
  output logic             busy,
  output logic             overrun,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic [CH_W-1:0]  res_chan,
  output logic             res_last
);
  logic               eng_start, eng_done;
  logic [FRAME_W-1:0] eng_tx, eng_rx;

  spi_frame_engine #(.HALF_DIV(HALF_DIV), .FW(FRAME_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .tx_word (eng_tx),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (eng_done),
    .rx_word (eng_rx)
  );

  scan_sequencer #(.HALF_DIV(HALF_DIV), .NCH(NCH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .chan_mask (chan_mask),
    .direct_rd (direct_rd),
    .direct_ch (direct_ch),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .cs_n      (cs_n),
    .busy      (busy),
    .overrun   (overrun),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .res_last  (res_last)
  );
endmodule

// File: rtl/adc_scan_checker.sv
module adc_scan_checker #(
  parameter int NCH = 8,
  parameter int CW  = 3,
  parameter int RW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig,
  input logic [NCH-1:0] chan_mask,
  input logic           direct_rd,
  input logic           busy,
  input logic           overrun,
  input logic           sclk,
  input logic           cs_n,
  input logic           res_valid,
  input logic           res_ready,
  input logic [RW-1:0]  res_data,
  input logic [CW-1:0]  res_chan,
  input logic           res_last
);
  // R1: released chip select implies SCLK resting high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R8: chip select only low inside a burst
  p_cs_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R9: an overrun pulse follows a trigger seen while busy
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(trig) && $past(busy)));

  // R10: empty mask in scan mode starts nothing
  p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && !direct_rd && chan_mask == '0) |=> !busy);

  // R11: stalled result holds steady
  p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_data) && $stable(res_chan) && $stable(res_last)));

  // R11: no SCLK activity while the output is stalled
  p_stall_sclk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> $stable(sclk));
endmodule

bind spi_adc_scan adc_scan_checker #(
  .NCH (NCH),
  .CW  (adc_scan_pkg::CH_W),
  .RW  (adc_scan_pkg::RES_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig      (trig),
  .chan_mask (chan_mask),
  .direct_rd (direct_rd),
  .busy      (busy),
  .overrun   (overrun),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_chan  (res_chan),
  .res_last  (res_last)
);

// File: tb/tb_spi_adc_scan.sv
`timescale 1ns/1ps
module tb_spi_adc_scan;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [7:0]  chan_mask = '0;
  logic        direct_rd = 1'b0;
  logic [2:0]  direct_ch = '0;
  logic        busy, overrun, sclk, cs_n, mosi;
  logic        miso = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [11:0] res_data;
  logic [2:0]  res_chan;
  logic        res_last;

  always #2.5 clk = ~clk;

  spi_adc_scan #(.HALF_DIV(HD), .NCH(8)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .chan_mask(chan_mask),
    .direct_rd(direct_rd), .direct_ch(direct_ch), .busy(busy),
    .overrun(overrun), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .res_last(res_last)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // converter model, sampled on falling system-clock edges
  logic [15:0] f_word [16];
  logic [11:0] f_exp  [16];
  int          f_n = 0;
  int          cs_falls = 0;
  int          frag = 0;
  int          idle_viol = 0;
  int          min_setup = 1000;
  int          min_hold  = 1000;
  logic        sclk_p = 1'b1, cs_p = 1'b1;
  logic [15:0] m_cmd = '0, m_resp = '0;
  int          m_bits = 0, nonce = 0, t_cs = 0, t_rise = 0;
  bit          want_first = 0;

  function automatic logic [15:0] resp_fn(input logic [2:0] ch, input int nz);
    logic [11:0] v;
    v = 12'(ch * 419) ^ 12'(nz * 91);
    return {4'(nz) ^ 4'h9, v};
  endfunction

  always @(negedge clk) begin
    if (cs_n && !sclk) idle_viol++;
    if (cs_p && !cs_n) begin
      m_bits = 0; m_resp = 16'hF5A5; t_cs = cyc; want_first = 1; cs_falls++;
    end
    if (!cs_n && sclk_p && !sclk) begin
      if (want_first) begin
        if (cyc - t_cs < min_setup) min_setup = cyc - t_cs;
        want_first = 0;
      end
      miso   = m_resp[15];
      m_resp = m_resp << 1;
    end
    if (!cs_n && !sclk_p && sclk) begin
      m_cmd = {m_cmd[14:0], mosi};
      m_bits++;
      t_rise = cyc;
      if (m_bits == 16) begin
        m_resp = resp_fn(m_cmd[13:11], nonce);
        if (f_n < 16) begin
          f_word[f_n] = m_cmd;
          f_exp[f_n]  = m_resp[11:0];
        end
        f_n++; nonce++; m_bits = 0;
      end
    end
    if (!cs_p && cs_n) begin
      if (m_bits != 0) frag++;
      if (cyc - t_rise < min_hold) min_hold = cyc - t_rise;
    end
    sclk_p = sclk;
    cs_p   = cs_n;
  end

  // consumer with back-pressure
  logic [11:0] o_data [16];
  logic [2:0]  o_chan [16];
  logic        o_last [16];
  int          o_n = 0;
  int          rdy_mode = 0;
  int          stab_viol = 0;
  bit          hold_p = 0;
  logic [15:0] saved = '0;

  always @(negedge clk) begin
    bit r;
    if (hold_p && (!res_valid || saved != {res_last, res_chan, res_data})) stab_viol++;
    r = (rdy_mode == 0) ? 1'b1 : 1'($urandom % 2);
    res_ready = r;
    if (res_valid && r) begin
      if (o_n < 16) begin
        o_data[o_n] = res_data; o_chan[o_n] = res_chan; o_last[o_n] = res_last;
      end
      o_n++;
      hold_p = 0;
    end else if (res_valid) begin
      hold_p = 1;
      saved  = {res_last, res_chan, res_data};
    end else begin
      hold_p = 0;
    end
  end

  task automatic run_scan(input logic [7:0] m, input logic d, input logic [2:0] dc,
                          input bit poke);
    int exp_ch[8];
    int n = 0;
    int falls0;
    if (d) begin exp_ch[0] = dc; n = 1; end
    else for (int c = 0; c < 8; c++) if (m[c]) begin exp_ch[n] = c; n++; end
    f_n = 0; o_n = 0; falls0 = cs_falls;
    @(negedge clk); trig = 1'b1; chan_mask = m; direct_rd = d; direct_ch = dc;
    @(negedge clk); trig = 1'b0;
    if (n == 0) begin
      repeat (20) @(negedge clk);
      chk(!busy, "R10 busy after empty trigger", busy, 0);
      chk(cs_falls == falls0 && f_n == 0, "R10 no chip select", f_n, 0);
      return;
    end
    if (poke) begin
      repeat (30) @(negedge clk);
      trig = 1'b1; chan_mask = 8'h01; direct_rd = 1'b0;
      @(negedge clk); trig = 1'b0;
      chk(overrun == 1'b1, "R9 overrun pulse", overrun, 1);
      @(negedge clk);
      chk(overrun == 1'b0, "R9 overrun single cycle", overrun, 0);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(f_n == n + 1, "R4 frame count", f_n, n + 1);
    chk(o_n == n, "R4 result count", o_n, n);
    if (f_n == n + 1 && o_n == n) begin
      for (int k = 0; k < n; k++)
        chk(f_word[k] == 16'(exp_ch[k] << 11), d ? "R7 direct command" : "R3 R2 command order",
            f_word[k], exp_ch[k] << 11);
      chk(f_word[n] == 16'h0000, "R4 dummy frame", f_word[n], 0);
      for (int i = 0; i < n; i++) begin
        chk(o_chan[i] == 3'(exp_ch[i]), "R5 channel tag", o_chan[i], exp_ch[i]);
        chk(o_data[i] == f_exp[i], "R5 result data", o_data[i], f_exp[i]);
        chk(o_last[i] == (i == n - 1), "R6 last flag", o_last[i], (i == n - 1));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !res_valid && !busy && !overrun, "R12 in reset",
        {cs_n, sclk, res_valid, busy, overrun}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && sclk && !res_valid && !busy && !overrun, "R12 after reset",
        {cs_n, sclk, res_valid, busy, overrun}, 5'b11000);

    // directed corners
    rdy_mode = 0;
    run_scan(8'hFF, 1'b0, 3'd0, 1'b0);   // R3 all channels
    run_scan(8'h80, 1'b0, 3'd0, 1'b0);   // R3 top only
    run_scan(8'h01, 1'b0, 3'd0, 1'b0);   // R3 bottom only
    run_scan(8'h00, 1'b0, 3'd0, 1'b0);   // R10
    run_scan(8'hFF, 1'b1, 3'd7, 1'b0);   // R7 mask ignored
    run_scan(8'h00, 1'b1, 3'd0, 1'b0);   // R7 direct with empty mask
    rdy_mode = 1;
    run_scan(8'hA5, 1'b0, 3'd0, 1'b1);   // R9 retrigger while busy, R11 stalls
    run_scan(8'h5A, 1'b0, 3'd0, 1'b0);

    // constrained random
    for (int t = 0; t < 24; t++) begin
      logic [7:0] m;
      logic       d;
      rdy_mode = $urandom % 2;
      m = 8'($urandom);
      d = ($urandom % 5) == 0;
      run_scan(m, d, 3'($urandom), ($urandom % 6) == 0);
    end

    chk(idle_viol == 0, "R1 sclk high while released", idle_viol, 0);
    chk(frag == 0, "R2 whole frames of 16 bits", frag, 0);
    chk(min_setup >= HD, "R8 chip select setup", min_setup, HD);
    chk(min_hold >= HD, "R8 chip select hold", min_hold, HD);
    chk(stab_viol == 0, "R11 result stable while stalled", stab_viol, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule